// File: doc/BRIEF.md
# Two-Wire Serial Configuration Register Port

This block is a slave-only two-wire serial port that lets an external host program and read back a bank of eight-bit configuration registers. Both bus lines are sampled in the system clock domain through synchronisers. The block recognises START, repeated START and STOP conditions on its own. It answers a single fixed device address, and it drives the data line only through an active-high pull-down enable. The pad and the pull-up resistor are outside the block.

A host transfer begins with the address byte, 7-bit address 0x44 followed by the direction bit. A write transfer then sends a sub-address byte that loads an internal pointer, followed by any number of data bytes. A read transfer first loads the pointer through a short write phase. It then issues a repeated START with the read address and clocks out data bytes. The pointer advances by one after every data byte in either direction. The top register slot holds a fixed identification value and cannot be written. The whole register bank is also presented in parallel on a flat output bus, so that the rest of the chip can use the settings.

Top module: `i2c_cfg_regport`

## Requirements
- R1: After reset every writable register holds 0x00 and the data-line pull-down enable is deasserted.
- R2: Only address bytes 0x88 (write) and 0x89 (read) are acknowledged. Any other address byte, including the general-call value 0x00, is left unacknowledged, and the block ignores the bus until the next START.
- R3: In a write transfer, the sub-address byte and every data byte are acknowledged by pulling the data line low for the ninth clock. Each data byte is stored at the pointer.
- R4: The pointer increments after every data byte. Slot 27 (0x1B) is followed by 0x00, and a pointer of 0xFF also rolls over to 0x00.
- R5: Sub-address 0x1B is the identification register. It always reads 0x12, and writes to it are acknowledged but leave it unchanged.
- R6: A sub-address of 28 or above is acknowledged. Writes to such a pointer are discarded, and reads return 0x00.
- R7: After a repeated START with 0x89, data bytes are sent MSB first, starting at the pointer. The pointer is kept across a STOP, so a later read without a write phase continues from it.
- R8: When the host answers a read byte with NACK, the block releases the data line and sends nothing until the next START or STOP. Further clocks read back as 0xFF.
- R9: The pull-down enable is asserted only while SCL is low.
- R10: A STOP returns the block to idle with the line released, so bytes clocked without a START are not acknowledged. A START at any point begins a new address phase.
- R11: Byte k of the configuration output bus, bits 8k+7 down to 8k, shows register k. The top slot shows the identification value 0x12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull the data line low when high |
| cfg_flat | output | NUM_REGS*8 | All registers side by side, register k in byte k |

## Verification
Some rules can be checked on every cycle, and the checker does so. The pull-down enable never rises while the synchronised clock is high. A STOP or START always leaves the line released in the expected state, and the line stays released while idle or ignoring the bus. No write ever reaches the identification slot, and an increment from the top slot always lands on zero. Only the bench's bus transactions can show that the right bytes are acknowledged, and that data arrives MSB first from the right pointer after wrap and rollover. They also show that out-of-range and general-call traffic leave the registers untouched, and that a host NACK turns later read clocks into all-ones.

// File: rtl/i2c_rf_pkg.sv
// Shared definitions for the serial configuration register port.
// Assumes: register width is one byte, as the serial protocol transfers bytes.
package i2c_rf_pkg;
    localparam int unsigned REG_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } rf_state_e;
endpackage

// File: rtl/i2c_rf_sync.sv
// Brings one asynchronous bus line into the system clock domain and flags its edges.
// Assumes: the line idles high, so the chain resets to ones. STAGES >= 2.
module i2c_rf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Keep the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/i2c_rf_regbank.sv
// Holds the writable configuration registers plus a constant identification slot.
// Assumes: the top slot (NUM_REGS-1) is read-only; pointers beyond it read as zero.
module i2c_rf_regbank #(
    parameter int unsigned  NUM_REGS = 28,
    parameter logic [7:0]   ID_VALUE = 8'h12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_flat
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);
    localparam logic [7:0]  LAST  = 8'(NUM_REGS - 1);

    logic [7:0] regs [NUM_REGS-1];

    for (genvar g = 0; g < NUM_REGS - 1; g++) begin : g_reg
        // Store a byte when the write port targets this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                             regs[g] <= 8'h00;
            else if (wr_en && wr_addr == 8'(g))     regs[g] <= wr_data;
        end
        assign cfg_flat[g*8 +: 8] = regs[g];
    end
    assign cfg_flat[NUM_REGS*8-1 -: 8] = ID_VALUE;

    // Select the byte at the read pointer: register, identification or zero.
    always_comb begin
        rd_data = 8'h00;
        if (rd_addr < LAST)       rd_data = regs[rd_addr[IDX_W-1:0]];
        else if (rd_addr == LAST) rd_data = ID_VALUE;
    end
endmodule

// File: rtl/i2c_rf_engine.sv
// Bus protocol engine: detects START and STOP, matches the device address, loads the
// pointer, moves data bytes with acknowledges and steps the pointer.
// Assumes: synchronised inputs; the enable only changes after a detected SCL fall,
// or when a START or STOP releases the line.
module i2c_rf_engine
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h44,
    parameter int unsigned NUM_REGS = 28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic [7:0] ptr,
    output logic       ptr_inc,
    output rf_state_e  state
);
    localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

    logic       start_c, stop_c;
    logic [3:0] bitcnt;
    logic [7:0] sh;
    logic [7:0] rd_sh;
    logic       rd_mode;
    logic       mack;
    logic [7:0] ptr_next;

    assign start_c  = sda_fall & scl_lvl;
    assign stop_c   = sda_rise & scl_lvl;
    assign ptr_next = (ptr == LAST) ? 8'h00 : ptr + 8'h01;
    assign ptr_inc  = scl_fall && bitcnt == 4'd8 && !start_c && !stop_c &&
                      (state == ST_WDATA || state == ST_RDATA);

    // Sequence the transfer one bus event at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            sh      <= '0;
            rd_sh   <= '0;
            rd_mode <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_c) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise) begin
                            sh     <= {sh[6:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (sh[7:1] == DEV_ADDR) begin
                                    rd_mode <= sh[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state   <= ST_IGNORE;
                                end
                            end else if (state == ST_SUB) begin
                                ptr    <= sh;
                                sda_oe <= 1'b1;
                                state  <= ST_SUB_ACK;
                            end else begin
                                wr_en   <= (ptr < LAST);
                                wr_addr <= ptr;
                                wr_data <= sh;
                                ptr     <= ptr_next;
                                sda_oe  <= 1'b1;
                                state   <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rd_mode) begin
                                rd_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_SUB;
                            end
                        end
                    end
                    ST_SUB_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr_next;
                                bitcnt <= '0;
                                state  <= ST_RACK;
                            end else begin
                                rd_sh  <= {rd_sh[6:0], 1'b0};
                                sda_oe <= ~rd_sh[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack) begin
                                rd_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                bitcnt <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_cfg_regport.sv
// Top level: synchronisers, protocol engine and register bank of the serial
// configuration port.
// Assumes: clk runs at least twenty times faster than SCL; no clock stretching.
module i2c_cfg_regport
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h44,
    parameter int unsigned NUM_REGS    = 28,
    parameter logic [7:0]  ID_VALUE    = 8'h12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe,
    output logic [NUM_REGS*REG_W-1:0] cfg_flat
);
    logic       scl_lvl, scl_rise, scl_fall;
    logic       sda_lvl, sda_rise, sda_fall;
    logic       wr_en, ptr_inc;
    logic [7:0] wr_addr, wr_data, ptr, rd_data;
    rf_state_e  eng_state;

    i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_i),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_i),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    i2c_rf_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .rd_data(rd_data), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ptr(ptr), .ptr_inc(ptr_inc), .state(eng_state)
    );

    i2c_rf_regbank #(.NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE)) u_regbank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(ptr), .rd_data(rd_data), .cfg_flat(cfg_flat)
    );
endmodule

// File: rtl/i2c_cfg_regport_checker.sv
// Cycle-by-cycle rules of the serial configuration port, attached to the top by bind.
// Assumes: signals are observed in the system clock domain after synchronisation.
module i2c_cfg_regport_checker
    import i2c_rf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 28
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       sda_rise,
    input logic       sda_fall,
    input logic       sda_oe,
    input rf_state_e  state,
    input logic [7:0] ptr,
    input logic       ptr_inc,
    input logic       wr_en,
    input logic [7:0] wr_addr
);
    localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

    logic start_c, stop_c;
    assign start_c = sda_fall & scl_lvl;
    assign stop_c  = sda_rise & scl_lvl;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_oe)); // R9

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (state == ST_IDLE && !sda_oe)); // R10

    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (state == ST_ADDR && !sda_oe)); // R10

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe); // R2

    AST_ID_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < LAST)); // R5

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && ptr == LAST) |=> (ptr == 8'h00)); // R4
endmodule

bind i2c_cfg_regport i2c_cfg_regport_checker #(.NUM_REGS(NUM_REGS)) u_checker (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_rise(sda_rise),
    .sda_fall(sda_fall), .sda_oe(sda_oe), .state(eng_state), .ptr(ptr),
    .ptr_inc(ptr_inc), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/i2c_cfg_regport_bench.sv
module i2c_cfg_regport_bench;
    localparam int NREG = 28;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg;
    logic sda_line;
    assign sda_line = m_sda & ~sda_oe;

    i2c_cfg_regport u_i2c_cfg_regport (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_flat(cfg)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int viol   = 0;
    bit done   = 0;
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    // R9 monitor: the pull-down must never rise while SCL stays high.
    always @(negedge clk) begin
        if (rst_n && scl && prev_scl && sda_oe && !prev_oe) viol++;
        prev_scl = scl;
        prev_oe  = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl) begin
            qw(1); m_sda = 1'b1; qw(1); scl = 1'b1;
        end
        qw(1); m_sda = 1'b0; qw(1); scl = 1'b0; qw(1);
    endtask

    task automatic bus_stop();
        qw(1); m_sda = 1'b0; qw(1); scl = 1'b1; qw(1); m_sda = 1'b1; qw(1);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            qw(1); m_sda = b[i]; qw(1); scl = 1'b1; qw(2); scl = 1'b0;
        end
        qw(1); m_sda = 1'b1; qw(1); scl = 1'b1; qw(1); ack = ~sda_line; qw(1); scl = 1'b0;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; qw(2); scl = 1'b1; qw(1); b = {b[6:0], sda_line}; qw(1); scl = 1'b0;
        end
        qw(1); m_sda = ~give_ack; qw(1); scl = 1'b1; qw(2); scl = 1'b0;
    endtask

    // {sub-address, data written, value expected on read-back}
    localparam logic [23:0] VEC [0:5] = '{
        24'h00_A5_A5, 24'h05_3C_3C, 24'h1A_5A_5A,
        24'h1B_55_12, 24'h1C_77_00, 24'h10_C0_C0
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2, a3, a4;
        logic [7:0] d, d1, d2;
        logic [7:0] sub;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 and R11: reset state
        chk("R1 oe after reset", sda_oe, 1'b0);
        chk("R1 reg00 reset", cfg[0 +: 8], 8'h00);
        chk("R1 reg1A reset", cfg[26*8 +: 8], 8'h00);
        chk("R11 id slot", cfg[27*8 +: 8], 8'h12);

        // Table: single write then read-back through a repeated START
        for (int i = 0; i < 6; i++) begin
            sub = VEC[i][23:16];
            bus_start();
            wbyte(8'h88, a0); wbyte(sub, a1); wbyte(VEC[i][15:8], a2);
            bus_stop();
            chk("R3 addr ack", a0, 1'b1);
            chk("R3 R6 sub ack", a1, 1'b1);
            chk("R3 R5 R6 data ack", a2, 1'b1);
            bus_start();
            wbyte(8'h88, a0); wbyte(sub, a1);
            bus_start();
            wbyte(8'h89, a3);
            rbyte(1'b0, d);
            bus_stop();
            chk("R2 R10 read addr ack", a3, 1'b1);
            chk("R7 R5 R6 read-back", d, VEC[i][7:0]);
            if (sub < NREG) chk("R11 cfg byte", cfg[int'(sub)*8 +: 8], VEC[i][7:0]);
        end

        // R4: burst write across the top slot wraps to 0x00
        bus_start();
        wbyte(8'h88, a0); wbyte(8'h1A, a1);
        wbyte(8'hA1, a2); wbyte(8'hB2, a3); wbyte(8'hC3, a4);
        bus_stop();
        chk("R4 burst ack", a4, 1'b1);
        chk("R4 reg1A", cfg[26*8 +: 8], 8'hA1);
        chk("R5 id kept", cfg[27*8 +: 8], 8'h12);
        chk("R4 wrap reg00", cfg[0 +: 8], 8'hC3);

        // R7 R4 R8: burst read across wrap, NACK, then idle clocks read 0xFF
        bus_start();
        wbyte(8'h88, a0); wbyte(8'h1A, a1);
        bus_start();
        wbyte(8'h89, a3);
        rbyte(1'b1, d); rbyte(1'b1, d1); rbyte(1'b0, d2);
        chk("R7 burst byte0", d, 8'hA1);
        chk("R5 burst id", d1, 8'h12);
        chk("R4 burst wrap", d2, 8'hC3);
        rbyte(1'b0, d);
        chk("R8 released after nack", d, 8'hFF);
        bus_stop();

        // R4 R6: pointer 0xFF discards its byte and rolls over to 0x00
        bus_start();
        wbyte(8'h88, a0); wbyte(8'hFF, a1); wbyte(8'h11, a2); wbyte(8'h22, a3);
        bus_stop();
        chk("R6 sub FF ack", a1, 1'b1);
        chk("R4 rollover reg00", cfg[0 +: 8], 8'h22);

        // R2: general call is not acknowledged and its bytes change nothing
        bus_start();
        wbyte(8'h00, a0); wbyte(8'h05, a1); wbyte(8'h99, a2);
        bus_stop();
        chk("R2 gcall nack", a0, 1'b0);
        chk("R2 gcall sub nack", a1, 1'b0);
        chk("R2 gcall data nack", a2, 1'b0);
        chk("R2 reg05 untouched", cfg[5*8 +: 8], 8'h3C);

        // R2: neighbouring addresses not acknowledged
        bus_start(); wbyte(8'h8A, a0); bus_stop();
        chk("R2 wrong write addr", a0, 1'b0);
        bus_start(); wbyte(8'h8B, a0); bus_stop();
        chk("R2 wrong read addr", a0, 1'b0);

        // R10: bytes after STOP without START are not acknowledged
        wbyte(8'h88, a0);
        chk("R10 no ack without start", a0, 1'b0);
        bus_stop();

        // R7: pointer survives STOP; a plain read continues from it
        bus_start(); wbyte(8'h88, a0); wbyte(8'h05, a1); bus_stop();
        bus_start(); wbyte(8'h89, a0); rbyte(1'b1, d); rbyte(1'b0, d1); bus_stop();
        chk("R7 direct read", d, 8'h3C);
        chk("R7 direct read next", d1, 8'h00);

        // R9: monitor result
        chk("R9 oe rose with scl high", viol, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule